// File: doc/BRIEF.md
# Zero-Overhead Loop Sequencer

This block keeps the three control registers a 32-bit core needs to run a block of instructions as a hardware loop, so that no branch instruction is needed. These registers are the loop start address, the loop end address and the remaining pass count. The block watches the fetch address. When fetch reaches the last instruction of the loop and another pass is due, the block asks the fetch unit, in that same cycle, to continue at the loop start.

There are two commands. A counted command sets the start address to the command's PC plus 4. It sets the end address to the command's PC plus a sign-extended 17-bit displacement, with bit 0 cleared. It also loads the pass count from a register value. An endless command sets the same two addresses, but it sets bit 0 of the end address, and that bit alone selects the endless mode. It does not touch the count.

All three registers can also be read and written through the core's control-register move path. Software can therefore save, restore or retarget a loop. For example, clearing bit 0 of the end address turns an endless loop into a counted one.

Top module: `zol_ctrl`

## Requirements
- R1: After reset the start, end and count registers read zero, loop_active is 0 and redirect is 0.
- R2: A counted command (rep_start=1, rep_endless=0) loads start = rep_pc + 4, end = rep_pc + sign-extended rep_disp with bit 0 forced to 0, and count = rep_count, and it sets loop_active. The new values are visible from the next cycle.
- R3: An endless command (rep_endless=1) loads start and end in the same way, but with end bit 0 forced to 1. It leaves count unchanged and sets loop_active. If both commands are raised together, the endless command wins.
- R4: While loop_active=1 and fetch_valid=1, a fetch address whose bits 31..1 equal end bits 31..1 is an end hit (fetch_pc bit 0 is ignored). On an end hit with end bit 0 set, or with a nonzero count, redirect is 1 in the same cycle and redirect_pc equals the start register.
- R5: redirect stays 0 when loop_active is 0, when fetch_valid is 0, or when the fetch address does not match the end address.
- R6: In counted mode (end bit 0 = 0), each redirect decrements the count by one. A loop loaded with count N therefore redirects exactly N times.
- R7: In counted mode, an end hit with count 0 gives no redirect, and loop_active falls to 0 in the next cycle.
- R8: In endless mode, redirects never change the count, and loop_active stays 1.
- R9: Control-register select codes are 0 = start, 1 = end, 2 = count, 3 = reserved. cr_rdata is combinational from cr_sel. Code 3 reads zero, and a write to code 3 changes no register.
- R10: When a count write and a redirect decrement fall in the same cycle, the written value is kept. When a repeat command and a control-register write fall in the same cycle, the command's values are kept.
- R11: A software write of the end register with bit 0 cleared turns a running endless loop into a counted loop. That loop then exits at the first end hit with count 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_valid | input | 1 | fetch_pc is a real fetch this cycle |
| fetch_pc | input | 32 | Current fetch address |
| rep_start | input | 1 | Counted repeat command |
| rep_endless | input | 1 | Endless repeat command |
| rep_pc | input | 32 | Address of the repeat command |
| rep_disp | input | 17 | Signed displacement to the loop end |
| rep_count | input | 32 | Pass count for a counted repeat |
| cr_we | input | 1 | Control-register write strobe |
| cr_sel | input | 2 | Control-register select (0 start, 1 end, 2 count) |
| cr_wdata | input | 32 | Control-register write data |
| cr_rdata | output | 32 | Control-register read data |
| redirect | output | 1 | Fetch must continue at redirect_pc |
| redirect_pc | output | 32 | Loop start address |
| loop_active | output | 1 | A loop is armed |

## Verification
Two pairs of updates can collide in one cycle. The first is a wrap of a counted loop with a software write of the count. The bench holds fetch at the end address while it writes a new count, confirms that redirect is still raised that cycle, and then reads back the written value rather than the decremented one. The second is a repeat command with a software write of the end register. Here the bench checks that the read-back end address and mode bit come from the command.

// File: rtl/zol_ctrl.sv
module zol_ctrl #(
  parameter int AW = 32,
  parameter int DW = 17,
  parameter int CW = 32,
  parameter int SEL_W = 2,
  parameter int INSN_BYTES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fetch_valid,
  input  logic [AW-1:0]    fetch_pc,
  input  logic             rep_start,
  input  logic             rep_endless,
  input  logic [AW-1:0]    rep_pc,
  input  logic [DW-1:0]    rep_disp,
  input  logic [CW-1:0]    rep_count,
  input  logic             cr_we,
  input  logic [SEL_W-1:0] cr_sel,
  input  logic [AW-1:0]    cr_wdata,
  output logic [AW-1:0]    cr_rdata,
  output logic             redirect,
  output logic [AW-1:0]    redirect_pc,
  output logic             loop_active
);
  localparam int XW = AW - DW;
  localparam logic [AW-1:0]    BEG_OFS = AW'(INSN_BYTES);
  localparam logic [SEL_W-1:0] SEL_BEG = SEL_W'(0);
  localparam logic [SEL_W-1:0] SEL_END = SEL_W'(1);
  localparam logic [SEL_W-1:0] SEL_CNT = SEL_W'(2);

  logic [AW-1:0] beg_q, end_q;
  logic [CW-1:0] cnt_q;
  logic          act_q;

  wire           cmd     = rep_start | rep_endless;
  wire [AW-1:0]  disp_x  = {{XW{rep_disp[DW-1]}}, rep_disp};
  wire [AW-1:0]  tgt     = rep_pc + disp_x;
  wire           endless = end_q[0];
  wire           at_end  = act_q & fetch_valid & (fetch_pc[AW-1:1] == end_q[AW-1:1]);
  wire           more    = endless | (cnt_q != '0);
  wire           wr_beg  = cr_we & (cr_sel == SEL_BEG);
  wire           wr_end  = cr_we & (cr_sel == SEL_END);
  wire           wr_cnt  = cr_we & (cr_sel == SEL_CNT);

  assign redirect    = at_end & more;
  assign redirect_pc = beg_q;
  assign loop_active = act_q;

  always_comb begin
    case (cr_sel)
      SEL_BEG: cr_rdata = beg_q;
      SEL_END: cr_rdata = end_q;
      SEL_CNT: cr_rdata = AW'(cnt_q);
      default: cr_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beg_q <= '0;
      end_q <= '0;
      cnt_q <= '0;
      act_q <= 1'b0;
    end else if (cmd) begin
      beg_q <= rep_pc + BEG_OFS;
      end_q <= {tgt[AW-1:1], rep_endless};
      if (!rep_endless) cnt_q <= rep_count;
      act_q <= 1'b1;
    end else begin
      if (wr_beg) beg_q <= cr_wdata;
      if (wr_end) end_q <= cr_wdata;
      if (wr_cnt) cnt_q <= CW'(cr_wdata);
      else if (redirect && !endless) cnt_q <= cnt_q - CW'(1);
      if (at_end && !more) act_q <= 1'b0;
    end
  end

  a_r2_counted_load: assert property (@(posedge clk) disable iff (!rst_n)
    (rep_start && !rep_endless) |=> (act_q && !end_q[0] && cnt_q == $past(rep_count)
                                     && beg_q == $past(rep_pc) + BEG_OFS));

  a_r3_endless_keeps_count: assert property (@(posedge clk) disable iff (!rst_n)
    rep_endless |=> (act_q && end_q[0] && $stable(cnt_q)));

  a_r5_idle_no_redirect: assert property (@(posedge clk) disable iff (!rst_n)
    !loop_active |-> !redirect);

  a_r6_wrap_decrements: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect && !end_q[0] && !cmd && !wr_cnt) |=> cnt_q == $past(cnt_q) - CW'(1));

  a_r7_exhaust_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (at_end && !end_q[0] && cnt_q == '0 && !cmd) |=> !loop_active);

  a_r8_endless_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_active && end_q[0] && !cmd && !cr_we) |=> (loop_active && $stable(cnt_q)));

  a_r10_write_beats_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd && wr_cnt) |=> cnt_q == CW'($past(cr_wdata)));
endmodule

// File: tb/zol_ctrl_test.sv
module zol_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fetch_valid = 1'b0;
  logic [31:0] fetch_pc = '0;
  logic        rep_start = 1'b0;
  logic        rep_endless = 1'b0;
  logic [31:0] rep_pc = '0;
  logic [16:0] rep_disp = '0;
  logic [31:0] rep_count = '0;
  logic        cr_we = 1'b0;
  logic [1:0]  cr_sel = '0;
  logic [31:0] cr_wdata = '0;
  logic [31:0] cr_rdata;
  logic        redirect;
  logic [31:0] redirect_pc;
  logic        loop_active;

  int checks = 0;
  int errors = 0;

  zol_ctrl uut (
    .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_pc(fetch_pc),
    .rep_start(rep_start), .rep_endless(rep_endless), .rep_pc(rep_pc),
    .rep_disp(rep_disp), .rep_count(rep_count), .cr_we(cr_we), .cr_sel(cr_sel),
    .cr_wdata(cr_wdata), .cr_rdata(cr_rdata), .redirect(redirect),
    .redirect_pc(redirect_pc), .loop_active(loop_active)
  );

  always #5 clk = ~clk;

  initial begin
    #1500000;
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_end(input logic [31:0] pc, input logic [16:0] d, input bit e);
    longint s;
    logic [31:0] r;
    s = d[16] ? longint'(d) - 131072 : longint'(d);
    r = 32'(longint'(pc) + s);
    r[0] = e;
    return r;
  endfunction

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [31:0] v);
    cr_sel = sel;
    #1;
    v = cr_rdata;
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] v);
    cr_we = 1'b1; cr_sel = sel; cr_wdata = v;
    step();
    cr_we = 1'b0;
  endtask

  task automatic cmd(input logic [31:0] pc, input logic [16:0] d, input logic [31:0] c, input bit e);
    rep_pc = pc; rep_disp = d; rep_count = c;
    rep_start = !e; rep_endless = e;
    step();
    rep_start = 1'b0; rep_endless = 1'b0;
  endtask

  task automatic run_counted(input int n, input logic [31:0] pc, input logic [16:0] d);
    logic [31:0] e, v;
    cmd(pc, d, 32'(n), 1'b0);
    e = exp_end(pc, d, 1'b0);
    rd(2'd1, v); chk("R2 end", v, e);
    rd(2'd2, v); chk("R2 count", v, 32'(n));
    rd(2'd0, v); chk("R2 start", v, pc + 32'd4);
    chk("R2 active", 32'(loop_active), 32'd1);
    for (int k = n; k >= 0; k--) begin
      fetch_pc = pc + 32'd4; fetch_valid = 1'b1; #1;
      chk("R5 body fetch", 32'(redirect), 32'd0);
      fetch_pc = e | 32'(k & 1); #1;
      chk("R4 redirect", 32'(redirect), 32'(k != 0));
      if (k != 0) chk("R4 target", redirect_pc, pc + 32'd4);
      step();
      fetch_valid = 1'b0;
      rd(2'd2, v);
      chk("R6 count", v, (k != 0) ? 32'(k - 1) : 32'd0);
    end
    chk("R7 inactive", 32'(loop_active), 32'd0);
    fetch_pc = e; fetch_valid = 1'b1; #1;
    chk("R5 after exit", 32'(redirect), 32'd0);
    fetch_valid = 1'b0;
  endtask

  initial begin
    logic [31:0] v, e, pc;
    logic [16:0] d;
    step(); step();
    rd(2'd0, v); chk("R1 start", v, 32'd0);
    rd(2'd1, v); chk("R1 end", v, 32'd0);
    rd(2'd2, v); chk("R1 count", v, 32'd0);
    chk("R1 active", 32'(loop_active), 32'd0);
    chk("R1 redirect", 32'(redirect), 32'd0);
    rst_n = 1'b1;
    step();

    for (int i = 0; i < 1024; i++) begin
      pc = 32'h1000_0000 + 32'(i * 36);
      if (i >= 1000) pc = 32'hFFFF_FFF0 - 32'(i - 1000) * 4;
      d = 17'(i * 129 + 7);
      if (i[2]) d[16] = 1'b1;
      cmd(pc, d, 32'(i), i[0]);
      e = exp_end(pc, d, i[0]);
      rd(2'd1, v); chk(i[0] ? "R3 end" : "R2 end", v, e);
      rd(2'd0, v); chk("R2 start", v, pc + 32'd4);
      rd(2'd2, v);
      if (!i[0]) chk("R2 count", v, 32'(i));
      else chk("R3 count kept", v, 32'(i - 1));
    end

    rep_pc = 32'h2000; rep_disp = 17'h40; rep_count = 32'd77;
    rep_start = 1'b1; rep_endless = 1'b1;
    step();
    rep_start = 1'b0; rep_endless = 1'b0;
    rd(2'd1, v); chk("R3 both end", v, 32'h2041);
    rd(2'd2, v); chk("R3 both count", v, 32'd1022);

    for (int n = 0; n <= 6; n++)
      run_counted(n, 32'h0000_4000 + 32'(n * 256), 17'(32 + n * 8));
    run_counted(3, 32'h0001_0000, 17'h1FFF0);

    wr(2'd2, 32'd5);
    cmd(32'h8000, 17'h20, 32'd0, 1'b1);
    e = 32'h8021;
    fetch_valid = 1'b1;
    for (int k = 0; k < 20; k++) begin
      fetch_pc = 32'h8020; #1;
      chk("R8 redirect", 32'(redirect), 32'd1);
      step();
      chk("R8 active", 32'(loop_active), 32'd1);
    end
    fetch_valid = 1'b0;
    rd(2'd2, v); chk("R8 count", v, 32'd5);

    fetch_pc = 32'h8020; #1;
    chk("R5 valid low", 32'(redirect), 32'd0);
    fetch_valid = 1'b1; fetch_pc = 32'h8024; #1;
    chk("R5 mismatch", 32'(redirect), 32'd0);
    fetch_valid = 1'b0;

    wr(2'd3, 32'hDEAD_BEEF);
    rd(2'd3, v); chk("R9 reserved", v, 32'd0);
    rd(2'd0, v); chk("R9 start kept", v, 32'h8004);
    rd(2'd1, v); chk("R9 end kept", v, e);
    rd(2'd2, v); chk("R9 count kept", v, 32'd5);
    wr(2'd0, 32'h0000_8008);
    rd(2'd0, v); chk("R9 start write", v, 32'h8008);
    chk("R9 target follows", redirect_pc, 32'h8008);

    wr(2'd2, 32'd1);
    wr(2'd1, 32'h8020);
    chk("R11 still active", 32'(loop_active), 32'd1);
    fetch_valid = 1'b1; fetch_pc = 32'h8020; #1;
    chk("R11 wrap", 32'(redirect), 32'd1);
    step();
    rd(2'd2, v); chk("R11 count", v, 32'd0);
    fetch_pc = 32'h8020; #1;
    chk("R11 exit", 32'(redirect), 32'd0);
    step();
    fetch_valid = 1'b0;
    chk("R11 inactive", 32'(loop_active), 32'd0);

    cmd(32'hA000, 17'h10, 32'd3, 1'b0);
    fetch_valid = 1'b1; fetch_pc = 32'hA010;
    cr_we = 1'b1; cr_sel = 2'd2; cr_wdata = 32'd9; #1;
    chk("R10 wrap with write", 32'(redirect), 32'd1);
    step();
    cr_we = 1'b0; fetch_valid = 1'b0;
    rd(2'd2, v); chk("R10 write wins", v, 32'd9);

    rep_pc = 32'hB000; rep_disp = 17'h30; rep_count = 32'd4; rep_start = 1'b1;
    cr_we = 1'b1; cr_sel = 2'd1; cr_wdata = 32'h1234_5677;
    step();
    rep_start = 1'b0; cr_we = 1'b0;
    rd(2'd1, v); chk("R10 command wins", v, 32'hB030);
    rd(2'd2, v); chk("R10 command count", v, 32'd4);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule